// File: doc/BRIEF.md
# Streaming 3x3 Binary Morphology Filter

This block performs binary dilation or binary erosion with a full 3x3 square structuring element on an image that arrives as a serial pixel stream. Pixels come in one per accepted clock, row by row, left to right. The result leaves as a stream in the same raster order, with one output pixel for each input pixel. Two one-bit line stores and a set of column registers hold a sliding 3x3 neighbourhood. Each row of that neighbourhood is reduced to a registered three-pixel count. The three counts are added into a nine-pixel population count, and a threshold that depends on the mode turns that count into the output bit.

The source marks the first pixel of a frame. The operation is chosen once per frame. Neighbours that fall outside the image are replaced by a neutral value: 0 for dilation and 1 for erosion, so frame edges neither grow nor shrink objects by themselves. The last image line of the window only completes after the final input pixel. The block therefore drains the remaining outputs on its own in the cycles that follow.

Top module: `morph_filter`

## Requirements
- R1: A frame begins with a cycle in which `valid_i` and `sof_i` are both 1. That pixel is row 0, column 0, and the following `IMG_W*IMG_H-1` valid pixels fill the frame in raster order (row-major, left to right). Valid pixels before any frame start, or after the frame's last pixel and before the next frame start, are ignored and produce no output.
- R2: `mode_i` is sampled only in the frame-start cycle (0 = dilation, 1 = erosion) and governs the whole frame. Changing it later in the frame has no effect.
- R3: In dilation mode an output pixel is 1 exactly when at least one pixel of the 3x3 neighbourhood centred on it is 1 (window population count of at least 1).
- R4: In erosion mode an output pixel is 1 exactly when the window population count equals 9.
- R5: Neighbours outside the image count as 0 in dilation and as 1 in erosion. An all-zero frame therefore dilates to all zeros, and an all-one frame erodes to all ones, including its border pixels.
- R6: Each frame yields exactly `IMG_W*IMG_H` output pixels with `valid_o` = 1, in raster order, and no others.
- R7: The output for raster index k appears on `pix_o`/`valid_o` three clock edges after the edge that accepts input index k+`IMG_W`+1.
- R8: After the frame's last input pixel, the block itself supplies `IMG_W`+1 further window steps on consecutive cycles, so the last `IMG_W`+1 outputs come out back to back. The next frame start must come no earlier than that drain allows.
- R9: While `rst_ni` is low, `valid_o` and `pix_o` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input pixel qualifier |
| sof_i | input | 1 | Marks the first pixel of a frame (with valid_i) |
| pix_i | input | 1 | Binary input pixel |
| mode_i | input | 1 | 0 = dilation, 1 = erosion; sampled at frame start |
| valid_o | output | 1 | Output pixel qualifier |
| pix_o | output | 1 | Binary output pixel |

## Verification
The bench drives a deliberately odd width so that it attacks the column wrap. A window that fails to mask its left or right taps at a row end pulls in pixels from the neighbouring line, which falsely sets or clears edge pixels. Lone set and cleared pixels in corners and on edges expose wrong top or bottom row masking and a wrong padding value, which shows up as an eroded rim on an all-one frame. Further tests cover a dropped or short drain (missing final outputs or a broken back-to-back timing), a mode that follows `mode_i` mid-frame, and stray pixels before the first frame start or after a frame's end that leak into the stream.

// File: rtl/morph_pkg.sv
package morph_pkg;

  localparam int unsigned WIN      = 3;
  localparam int unsigned WIN_AREA = WIN * WIN;

  typedef enum logic {
    MODE_DILATE = 1'b0,
    MODE_ERODE  = 1'b1
  } morph_mode_e;

  // position flags of the window centre, travelling with the data
  typedef struct packed {
    logic vld;
    logic ero;
    logic top;
    logic bot;
    logic lft;
    logic rgt;
  } win_tag_t;

endpackage

// File: rtl/morph_line_buf.sv
module morph_line_buf #(
  parameter int unsigned DEPTH = 256,
  parameter int unsigned AW    = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          adv_i,
  input  logic [AW-1:0] ptr_i,
  input  logic          din_i,
  output logic          dout_o
);

  logic mem_q [DEPTH];

  // read-before-write at the shared column pointer: DEPTH-step delay
  assign dout_o = mem_q[ptr_i];

  always_ff @(posedge clk_i) begin
    if (adv_i) mem_q[ptr_i] <= din_i;
  end

endmodule

// File: rtl/morph_window.sv
module morph_window
  import morph_pkg::*;
#(
  parameter int unsigned IMG_W = 256,
  parameter int unsigned IMG_H = 256,
  parameter int unsigned COL_W = $clog2(IMG_W),
  parameter int unsigned ROW_W = $clog2(IMG_H + 2)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     valid_i,
  input  logic                     sof_i,
  input  logic                     pix_i,
  input  logic                     mode_i,
  output logic [WIN-1:0][WIN-1:0]  win_o,
  output win_tag_t                 tag_o
);

  localparam int unsigned NLB = WIN - 1;
  localparam logic [COL_W-1:0] COL_LAST  = COL_W'(IMG_W - 1);
  localparam logic [ROW_W-1:0] ROW_LAST  = ROW_W'(IMG_H - 1);
  localparam logic [ROW_W-1:0] ROW_DRAIN = ROW_W'(IMG_H + 1);

  typedef enum logic [1:0] {ST_IDLE, ST_FILL, ST_DRAIN} state_e;

  state_e           state_q, state_d;
  logic [COL_W-1:0] col_q, cur_col, nxt_col, ctr_col;
  logic [ROW_W-1:0] row_q, cur_row, nxt_row, ctr_row;
  logic             start, accept, adv, push_pix, ero_q, ero_cur, ctr_vld;
  logic [NLB-1:0]   lb_din, lb_dout;
  logic [WIN-1:0]   sh_q [WIN];  // [0] top row .. [WIN-1] bottom row; bit 0 newest
  win_tag_t         tag_q;

  assign start    = valid_i & sof_i;
  assign accept   = valid_i & (sof_i | (state_q == ST_FILL));
  assign adv      = accept | (state_q == ST_DRAIN);
  assign push_pix = accept & pix_i;   // drain steps push a don't-care 0
  assign cur_col  = start ? '0 : col_q;
  assign cur_row  = start ? '0 : row_q;
  assign ero_cur  = start ? mode_i : ero_q;

  always_comb begin
    if (cur_col == COL_LAST) begin
      nxt_col = '0;
      nxt_row = cur_row + ROW_W'(1);
    end else begin
      nxt_col = cur_col + COL_W'(1);
      nxt_row = cur_row;
    end
  end

  always_comb begin
    state_d = state_q;
    if (accept) begin
      state_d = (cur_row == ROW_LAST && cur_col == COL_LAST) ? ST_DRAIN : ST_FILL;
    end else if (adv && cur_row == ROW_DRAIN) begin
      state_d = ST_IDLE;
    end
  end

  // window centre trails the newest pixel by one line plus one pixel
  assign ctr_vld = (cur_row > ROW_W'(1)) || (cur_row == ROW_W'(1) && cur_col != '0);
  assign ctr_col = (cur_col == '0) ? COL_LAST : cur_col - COL_W'(1);
  assign ctr_row = (cur_col == '0) ? cur_row - ROW_W'(2) : cur_row - ROW_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      col_q   <= '0;
      row_q   <= '0;
      ero_q   <= 1'b0;
      tag_q   <= '0;
    end else begin
      state_q <= state_d;
      if (adv) begin
        col_q <= nxt_col;
        row_q <= nxt_row;
      end
      if (start) ero_q <= mode_i;
      tag_q <= '{vld: adv & ctr_vld,
                 ero: ero_cur,
                 top: (ctr_row == '0),
                 bot: (ctr_row == ROW_LAST),
                 lft: (ctr_col == '0),
                 rgt: (ctr_col == COL_LAST)};
    end
  end

  assign lb_din[0] = push_pix;
  for (genvar i = 1; i < NLB; i++) begin : g_lb_chain
    assign lb_din[i] = lb_dout[i-1];
  end

  for (genvar i = 0; i < NLB; i++) begin : g_lb
    morph_line_buf #(
      .DEPTH(IMG_W),
      .AW   (COL_W)
    ) u_lb (
      .clk_i (clk_i),
      .adv_i (adv),
      .ptr_i (cur_col),
      .din_i (lb_din[i]),
      .dout_o(lb_dout[i])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int r = 0; r < WIN; r++) sh_q[r] <= '0;
    end else if (adv) begin
      sh_q[WIN-1] <= {sh_q[WIN-1][WIN-2:0], push_pix};
      for (int i = 0; i < NLB; i++) begin
        sh_q[WIN-2-i] <= {sh_q[WIN-2-i][WIN-2:0], lb_dout[i]};
      end
    end
  end

  for (genvar r = 0; r < WIN; r++) begin : g_row
    for (genvar c = 0; c < WIN; c++) begin : g_col
      assign win_o[r][c] = sh_q[r][WIN-1-c];
    end
  end

  assign tag_o = tag_q;

endmodule

// File: rtl/morph_sum.sv
module morph_sum
  import morph_pkg::*;
#(
  parameter int unsigned PSUM_W = 11,
  parameter int unsigned SUM_W  = 12
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [WIN-1:0][WIN-1:0] win_i,
  input  win_tag_t                tag_i,
  output logic [SUM_W-1:0]        sum_o,
  output win_tag_t                tag_o
);

  logic [WIN-1:0][WIN-1:0]    msk;
  logic [WIN-1:0][PSUM_W-1:0] psum_d, psum_q;
  logic [SUM_W-1:0]           sum_d, sum_q;
  win_tag_t                   tag_a_q, tag_b_q;

  // replace taps outside the image by the mode's neutral value
  for (genvar r = 0; r < WIN; r++) begin : g_mr
    for (genvar c = 0; c < WIN; c++) begin : g_mc
      assign msk[r][c] = ((r == 0       && tag_i.top) ||
                          (r == WIN - 1 && tag_i.bot) ||
                          (c == 0       && tag_i.lft) ||
                          (c == WIN - 1 && tag_i.rgt)) ? tag_i.ero : win_i[r][c];
    end
  end

  always_comb begin
    for (int r = 0; r < WIN; r++) begin
      psum_d[r] = '0;
      for (int c = 0; c < WIN; c++) psum_d[r] = psum_d[r] + PSUM_W'(msk[r][c]);
    end
  end

  always_comb begin
    sum_d = '0;
    for (int r = 0; r < WIN; r++) sum_d = sum_d + SUM_W'(psum_q[r]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      psum_q  <= '0;
      sum_q   <= '0;
      tag_a_q <= '0;
      tag_b_q <= '0;
    end else begin
      psum_q  <= psum_d;
      tag_a_q <= tag_i;
      sum_q   <= sum_d;
      tag_b_q <= tag_a_q;
    end
  end

  assign sum_o = sum_q;
  assign tag_o = tag_b_q;

endmodule

// File: rtl/morph_filter.sv
module morph_filter
  import morph_pkg::*;
#(
  parameter int unsigned IMG_W  = 256,
  parameter int unsigned IMG_H  = 256,
  parameter int unsigned PSUM_W = 11,
  parameter int unsigned SUM_W  = 12
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic valid_i,
  input  logic sof_i,
  input  logic pix_i,
  input  logic mode_i,
  output logic valid_o,
  output logic pix_o
);

  localparam int unsigned COL_W = $clog2(IMG_W);
  localparam int unsigned ROW_W = $clog2(IMG_H + 2);
  localparam logic [SUM_W-1:0] THR_ERO = SUM_W'(WIN_AREA);
  localparam logic [SUM_W-1:0] THR_DIL = SUM_W'(1);

  logic [WIN-1:0][WIN-1:0] win;
  win_tag_t                win_tag, sum_tag;
  logic [SUM_W-1:0]        sum;
  logic                    hit, valid_q, pix_q;

  morph_window #(
    .IMG_W(IMG_W),
    .IMG_H(IMG_H),
    .COL_W(COL_W),
    .ROW_W(ROW_W)
  ) u_window (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .valid_i(valid_i),
    .sof_i  (sof_i),
    .pix_i  (pix_i),
    .mode_i (mode_i),
    .win_o  (win),
    .tag_o  (win_tag)
  );

  morph_sum #(
    .PSUM_W(PSUM_W),
    .SUM_W (SUM_W)
  ) u_sum (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .win_i (win),
    .tag_i (win_tag),
    .sum_o (sum),
    .tag_o (sum_tag)
  );

  assign hit = sum_tag.ero ? (sum == THR_ERO) : (sum >= THR_DIL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      pix_q   <= 1'b0;
    end else begin
      valid_q <= sum_tag.vld;
      pix_q   <= sum_tag.vld & hit;
    end
  end

  assign valid_o = valid_q;
  assign pix_o   = pix_q;

endmodule

// File: rtl/morph_filter_chk.sv
module morph_filter_chk #(
  parameter int unsigned IMG_W = 256,
  parameter int unsigned IMG_H = 256
) (
  input logic clk_i,
  input logic rst_ni,
  input logic valid_i,
  input logic sof_i,
  input logic pix_i,
  input logic mode_i,
  input logic valid_o,
  input logic pix_o
);

  localparam int unsigned NPIX  = IMG_W * IMG_H;
  localparam int unsigned CNT_W = $clog2(NPIX + 1);
  localparam int unsigned DR_W  = $clog2(IMG_W + 2);

  logic             seen_q, ero_q, any1_q, any0_q;
  logic [CNT_W-1:0] in_cnt_q, out_cnt_q;
  logic [3:0]       last_pipe_q;
  logic [DR_W-1:0]  drain_q;
  logic             start, in_take, last_in;

  assign start   = valid_i & sof_i;
  assign in_take = valid_i & ~sof_i & seen_q & (in_cnt_q < CNT_W'(NPIX));
  assign last_in = in_take & (in_cnt_q == CNT_W'(NPIX - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q      <= 1'b0;
      ero_q       <= 1'b0;
      any1_q      <= 1'b0;
      any0_q      <= 1'b0;
      in_cnt_q    <= '0;
      out_cnt_q   <= '0;
      last_pipe_q <= '0;
      drain_q     <= '0;
    end else begin
      if (start) begin
        seen_q   <= 1'b1;
        ero_q    <= mode_i;
        any1_q   <= pix_i;
        any0_q   <= ~pix_i;
        in_cnt_q <= CNT_W'(1);
      end else if (in_take) begin
        any1_q   <= any1_q | pix_i;
        any0_q   <= any0_q | ~pix_i;
        in_cnt_q <= in_cnt_q + CNT_W'(1);
      end
      if (start)        out_cnt_q <= '0;
      else if (valid_o) out_cnt_q <= out_cnt_q + CNT_W'(1);
      last_pipe_q <= {last_pipe_q[2:0], last_in};
      if (last_pipe_q[3])     drain_q <= DR_W'(IMG_W + 1);
      else if (drain_q != '0) drain_q <= drain_q - DR_W'(1);
    end
  end

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      AST_RST_IDLE: assert (!valid_o && !pix_o); // R9
    end
  end

  AST_NO_OUT_UNSTARTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !seen_q |-> !valid_o); // R1

  AST_OUT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (out_cnt_q < CNT_W'(NPIX))); // R6

  AST_DIL_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && !ero_q && !any1_q && valid_o) |-> !pix_o); // R3

  AST_ERO_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && ero_q && !any0_q && valid_o) |-> pix_o); // R4

  AST_DRAIN_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drain_q != '0) |-> valid_o); // R8

endmodule

bind morph_filter morph_filter_chk #(
  .IMG_W(IMG_W),
  .IMG_H(IMG_H)
) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .valid_i(valid_i),
  .sof_i  (sof_i),
  .pix_i  (pix_i),
  .mode_i (mode_i),
  .valid_o(valid_o),
  .pix_o  (pix_o)
);

// File: tb/tb_morph_filter.sv
module tb_morph_filter;

  localparam int TW = 7;
  localparam int TH = 5;
  localparam int NP = TW * TH;
  localparam int OB = 256;

  typedef struct packed {
    logic       ero;
    logic [2:0] kind;  // 0 zero,1 one,2 rand,3 lone one,4 lone zero,5 checker,6 dense
    logic       gaps;
    logic [7:0] seed;  // lone pixel at row seed[7:4]%TH, col seed[3:0]%TW
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 3'd0, 1'b0, 8'h00},
    '{1'b1, 3'd1, 1'b0, 8'h00},
    '{1'b0, 3'd1, 1'b0, 8'h00},
    '{1'b1, 3'd0, 1'b0, 8'h00},
    '{1'b0, 3'd2, 1'b1, 8'h11},
    '{1'b1, 3'd2, 1'b1, 8'h22},
    '{1'b0, 3'd3, 1'b0, 8'h00},
    '{1'b1, 3'd4, 1'b0, 8'h46},
    '{1'b0, 3'd3, 1'b0, 8'h26},
    '{1'b1, 3'd6, 1'b0, 8'h33},
    '{1'b0, 3'd5, 1'b0, 8'h00},
    '{1'b1, 3'd6, 1'b1, 8'h5a}
  };

  logic clk = 1'b0;
  logic rst_ni = 1'b1;
  logic valid_i = 1'b0, sof_i = 1'b0, pix_i = 1'b0, mode_i = 1'b0;
  logic valid_o, pix_o;

  morph_filter #(.IMG_W(TW), .IMG_H(TH)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .sof_i(sof_i),
    .pix_i(pix_i), .mode_i(mode_i), .valid_o(valid_o), .pix_o(pix_o)
  );

  always #2 clk = ~clk;

  int n_chk = 0, n_fail = 0, cyc = 0, out_tot = 0;
  logic out_buf [OB];
  int   out_cyc [OB];
  int   in_edge [NP];
  logic img [TH][TW];
  logic [31:0] rng;

  always @(posedge clk) cyc = cyc + 1;

  always @(negedge clk) begin
    if (valid_o) begin
      out_buf[out_tot % OB] = pix_o;
      out_cyc[out_tot % OB] = cyc;
      out_tot = out_tot + 1;
    end
  end

  function automatic logic [31:0] xs(input logic [31:0] v);
    logic [31:0] t;
    t = v ^ (v << 13);
    t = t ^ (t >> 17);
    t = t ^ (t << 5);
    return t;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // neighbourhood rule from R3/R4/R5: outside pixels take the neutral value
  function automatic logic ref_px(input int r, input int c, input logic ero);
    logic any1 = 1'b0, all1 = 1'b1, v;
    for (int dr = -1; dr <= 1; dr++) begin
      for (int dc = -1; dc <= 1; dc++) begin
        if (r + dr < 0 || r + dr >= TH || c + dc < 0 || c + dc >= TW) v = ero;
        else v = img[r+dr][c+dc];
        any1 = any1 | v;
        all1 = all1 & v;
      end
    end
    return ero ? all1 : any1;
  endfunction

  task automatic build(input logic [2:0] kind, input logic [7:0] seed);
    int sr = int'(seed[7:4]) % TH;
    int sc = int'(seed[3:0]) % TW;
    rng = {24'hC0FFEE, seed};
    for (int r = 0; r < TH; r++) begin
      for (int c = 0; c < TW; c++) begin
        rng = xs(rng);
        case (kind)
          3'd0:    img[r][c] = 1'b0;
          3'd1:    img[r][c] = 1'b1;
          3'd2:    img[r][c] = rng[0];
          3'd3:    img[r][c] = (r == sr && c == sc);
          3'd4:    img[r][c] = !(r == sr && c == sc);
          3'd5:    img[r][c] = 1'((r + c) % 2);
          default: img[r][c] = rng[0] | rng[1];
        endcase
      end
    end
  endtask

  task automatic run_frame(input logic ero, input bit flip, input bit gaps,
                           input bit junk, input string req);
    int base = out_tot;
    int got;
    for (int k = 0; k < NP; k++) begin
      if (gaps && rng[0]) begin
        valid_i = 1'b0;
        @(negedge clk);
      end
      rng     = xs(rng);
      valid_i = 1'b1;
      sof_i   = (k == 0);
      pix_i   = img[k / TW][k % TW];
      mode_i  = (k == 0) ? ero : (flip ? ~ero : ero);
      in_edge[k] = cyc + 1;
      @(negedge clk);
    end
    sof_i = 1'b0;
    if (junk) begin
      for (int j = 0; j < TW + 1; j++) begin
        valid_i = 1'b1;
        pix_i   = rng[1];
        rng     = xs(rng);
        @(negedge clk);
      end
    end
    valid_i = 1'b0;
    pix_i   = 1'b0;
    mode_i  = 1'b0;
    for (int t = 0; t < 4 * NP && (out_tot - base) < NP; t++) @(negedge clk);
    repeat (8) @(negedge clk);
    chk(out_tot - base == NP, "R6 output count", out_tot - base, NP);
    for (int k = 0; k < NP; k++) begin
      got = int'(out_buf[(base + k) % OB]);
      chk(got == int'(ref_px(k / TW, k % TW, ero)), req, got,
          int'(ref_px(k / TW, k % TW, ero)));
    end
    chk(out_cyc[base % OB] == in_edge[TW + 1] + 3, "R7 first output edge",
        out_cyc[base % OB], in_edge[TW + 1] + 3);
    chk(out_cyc[(base + NP - 1) % OB] == in_edge[NP - 1] + TW + 4, "R8 drain end edge",
        out_cyc[(base + NP - 1) % OB], in_edge[NP - 1] + TW + 4);
  endtask

  initial begin
    rng = 32'h1234_5678;
    #1 rst_ni = 1'b0;
    repeat (3) @(negedge clk);
    chk(!valid_o && !pix_o, "R9 reset outputs", int'({valid_o, pix_o}), 0);
    rst_ni = 1'b1;
    @(negedge clk);

    // R1: pixels with no frame start are ignored
    for (int j = 0; j < 2 * TW; j++) begin
      valid_i = 1'b1;
      pix_i   = 1'b1;
      @(negedge clk);
    end
    valid_i = 1'b0;
    repeat (20) @(negedge clk);
    chk(out_tot == 0, "R1 no output before frame start", out_tot, 0);

    for (int i = 0; i < NV; i++) begin
      build(VECS[i].kind, VECS[i].seed);
      run_frame(VECS[i].ero, 1'b0, VECS[i].gaps, 1'b0,
                (VECS[i].kind <= 3'd1) ? "R5 padding" :
                (VECS[i].ero ? "R4 erosion" : "R3 dilation"));
    end

    // R2: mode toggled after frame start has no effect
    build(3'd6, 8'h71);
    run_frame(1'b1, 1'b1, 1'b0, 1'b0, "R2 mode latched (erosion)");
    build(3'd2, 8'h72);
    run_frame(1'b0, 1'b1, 1'b1, 1'b0, "R2 mode latched (dilation)");

    // R1: valid pixels during the drain are ignored
    build(3'd2, 8'h73);
    run_frame(1'b0, 1'b0, 1'b0, 1'b1, "R1 trailing pixels ignored");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog R6 actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule